// File: doc/BRIEF.md
# SDIO Card Bring-Up Sequencer

This block runs on the host side of an SDIO link. It takes a freshly powered card through the whole bring-up order, ending with the card selected and function 1 enabled. It talks to a command engine through a narrow interface. For each command it presents a command index and a 32-bit argument, raises a one-cycle start strobe, and then waits for a done strobe that carries the 32-bit response. The physical layer, the CRC and the line timing all belong to that engine. They are not part of this block.

The sequence has three phases. First it resets the card's I/O side and the memory side, and can optionally check the interface condition. Then it negotiates the operating voltage window, polling until the card reports ready. The number of polls is bounded. Finally it reads the card's relative address, selects the card with that address, and writes the function-0 control registers.

Configuration inputs turn on the optional steps: 4-bit bus mode, the interrupt enable, and the block-size programming for function 0 and function 1. Every block size that is written is read back and compared with the written value. The sequence ends in one of two states. The done state means bring-up succeeded. The error state means the poll limit was reached or a readback did not match.

Top module: `sdio_card_init_seq`

## Requirements
- R1: After reset the block is idle: `cmd_start`, `init_done` and `init_err` are all low.
- R2: Each command is announced by `cmd_start` high for exactly one cycle. `cmd_idx` and `cmd_arg` stay stable until `cmd_done` arrives. A `cmd_done` that arrives while no command is outstanding is ignored.
- R3: A direct register access uses index 52. Its argument is laid out as follows: bit 31 is the write flag (1 = write), bits 30..28 are the function number, which is always 0, bit 27 is 0, bits 25..9 are the register address, and bits 7..0 are the write data (0 for a read).
- R4: A start request first issues a write of 0x08 to register 0x006. It then issues index 0 with argument 0. Index 8 with argument 0x000001AA follows only when `cfg_send_if_cond` is high.
- R5: The first index-5 command has argument 0. Every later index-5 command carries 0x00 in bits 31..24 and, in bits 23..0, the bits 23..0 of the first index-5 response. These commands repeat until bit 31 of a response is 1.
- R6: If POLL_LIMIT index-5 commands with the voltage window all return bit 31 = 0, the block stops issuing commands and raises `init_err`.
- R7: Index 3 is issued with argument 0. Index 7 then carries bits 31..16 of the index-3 response in bits 31..16, with zeros in bits 15..0.
- R8: Next comes a write of 0x02 to register 0x007, only if `cfg_bus_4bit` is high. A write of 0x02 to register 0x002 always follows. After that comes a write of 0x03 to register 0x004, only if `cfg_irq_enable` is high.
- R9: When `cfg_set_f0_bsize` is high, the block writes the low byte of `f0_bsize` to 0x010 and the high byte to 0x011, then reads 0x010 and then 0x011. `cfg_set_f1_bsize` does the same with `f1_bsize` at 0x110/0x111. The function-0 group comes first.
- R10: If a readback's response bits 7..0 differ from the byte written, the block raises `init_err` and issues no further command.
- R11: After the last step `init_done` stays high with no further commands. A `start` while done or in error restarts the sequence, and a `start` during a sequence is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) bring-up |
| cfg_send_if_cond | input | 1 | Include the interface-condition command |
| cfg_bus_4bit | input | 1 | Select 4-bit bus width |
| cfg_irq_enable | input | 1 | Enable card interrupts |
| cfg_set_f0_bsize | input | 1 | Program and verify function-0 block size |
| cfg_set_f1_bsize | input | 1 | Program and verify function-1 block size |
| f0_bsize | input | 16 | Function-0 block size value |
| f1_bsize | input | 16 | Function-1 block size value |
| cmd_start | output | 1 | One-cycle command strobe |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_done | input | 1 | Command completion strobe |
| cmd_resp | input | 32 | Response, valid with `cmd_done` |
| init_done | output | 1 | Bring-up completed |
| init_err | output | 1 | Bring-up failed |

## Verification
The bench builds the block with POLL_LIMIT set to 4. This puts three cases within a few cycles of reach: a card that turns ready on the last permitted poll, a card that never turns ready and so drives the error path, and runs with random ready delays in between. The card model answers after a random latency. It keeps a byte store for the block-size registers and can corrupt readbacks, which exercises the mismatch path for each block-size group.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    typedef enum logic [4:0] {
        S_IDLE, S_IORST, S_GORST, S_IFCOND, S_OCR0, S_OCRN, S_RCA, S_SEL,
        S_BUS4, S_FN1, S_IRQ,
        S_B0WL, S_B0WH, S_B0RL, S_B0RH,
        S_B1WL, S_B1WH, S_B1RL, S_B1RH,
        S_DONE, S_ERR
    } step_e;

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
    } cmd_t;

    localparam logic [5:0]  CMD_GO_IDLE   = 6'd0;
    localparam logic [5:0]  CMD_REL_ADDR  = 6'd3;
    localparam logic [5:0]  CMD_OP_COND   = 6'd5;
    localparam logic [5:0]  CMD_SELECT    = 6'd7;
    localparam logic [5:0]  CMD_IF_COND   = 6'd8;
    localparam logic [5:0]  CMD_RW_DIRECT = 6'd52;
    localparam logic [31:0] IF_COND_ARG   = 32'h0000_01AA;

    localparam logic [16:0] REG_IO_ABORT = 17'h00006;
    localparam logic [16:0] REG_BUS_IF   = 17'h00007;
    localparam logic [16:0] REG_IO_EN    = 17'h00002;
    localparam logic [16:0] REG_INT_EN   = 17'h00004;
    localparam logic [16:0] REG_F0_BS    = 17'h00010;
    localparam logic [16:0] REG_F1_BS    = 17'h00110;

    // Direct register access argument: write flag, function, address, data.
    function automatic logic [31:0] rw_direct_arg(input logic wr, input logic [2:0] fn,
                                                  input logic [16:0] addr, input logic [7:0] data);
        return {wr, fn, 1'b0, 1'b0, addr, 1'b0, data};
    endfunction

    function automatic cmd_t wr0(input logic [16:0] addr, input logic [7:0] data);
        return '{idx: CMD_RW_DIRECT, arg: rw_direct_arg(1'b1, 3'd0, addr, data)};
    endfunction

    function automatic cmd_t rd0(input logic [16:0] addr);
        return '{idx: CMD_RW_DIRECT, arg: rw_direct_arg(1'b0, 3'd0, addr, 8'h00)};
    endfunction

endpackage

// File: rtl/sdinit_poll_ctr.sv
module sdinit_poll_ctr #(
    parameter int POLL_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(POLL_LIMIT + 1);
    localparam logic [CW-1:0] LAST_VAL = CW'(POLL_LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (inc && cnt_q != LAST_VAL)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == LAST_VAL);

    AST_POLL_CAP: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_VAL);  // R6

endmodule

// File: rtl/sdinit_resp_latch.sv
module sdinit_resp_latch (
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_win,
    input  logic        cap_rca,
    input  logic [31:0] resp,
    output logic [23:0] win,
    output logic [15:0] rca
);
    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
            rca <= '0;
        end else begin
            if (cap_win) win <= resp[23:0];
            if (cap_rca) rca <= resp[31:16];
        end
    end
endmodule

// File: rtl/sdio_card_init_seq.sv
module sdio_card_init_seq
    import sdinit_pkg::*;
#(
    parameter int POLL_LIMIT = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        cfg_send_if_cond,
    input  logic        cfg_bus_4bit,
    input  logic        cfg_irq_enable,
    input  logic        cfg_set_f0_bsize,
    input  logic        cfg_set_f1_bsize,
    input  logic [15:0] f0_bsize,
    input  logic [15:0] f1_bsize,
    output logic        cmd_start,
    output logic [5:0]  cmd_idx,
    output logic [31:0] cmd_arg,
    input  logic        cmd_done,
    input  logic [31:0] cmd_resp,
    output logic        init_done,
    output logic        init_err
);
    step_e st_q, st_d;
    logic  wait_q, wait_d;
    logic  cap_win, cap_rca, poll_clr, poll_inc, poll_last;
    logic  [23:0] win;
    logic  [15:0] rca;
    logic  accept, can_start;
    cmd_t  cmd;
    step_e bs_entry, after_f0;

    sdinit_poll_ctr #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
        .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .last(poll_last)
    );

    sdinit_resp_latch u_latch (
        .clk(clk), .rst(rst), .cap_win(cap_win), .cap_rca(cap_rca),
        .resp(cmd_resp), .win(win), .rca(rca)
    );

    // Command presented in each step.
    always_comb begin
        cmd = '{idx: CMD_GO_IDLE, arg: 32'h0};
        unique case (st_q)
            S_IORST:  cmd = wr0(REG_IO_ABORT, 8'h08);
            S_GORST:  cmd = '{idx: CMD_GO_IDLE, arg: 32'h0};
            S_IFCOND: cmd = '{idx: CMD_IF_COND, arg: IF_COND_ARG};
            S_OCR0:   cmd = '{idx: CMD_OP_COND, arg: 32'h0};
            S_OCRN:   cmd = '{idx: CMD_OP_COND, arg: {8'h00, win}};
            S_RCA:    cmd = '{idx: CMD_REL_ADDR, arg: 32'h0};
            S_SEL:    cmd = '{idx: CMD_SELECT, arg: {rca, 16'h0000}};
            S_BUS4:   cmd = wr0(REG_BUS_IF, 8'h02);
            S_FN1:    cmd = wr0(REG_IO_EN, 8'h02);
            S_IRQ:    cmd = wr0(REG_INT_EN, 8'h03);
            S_B0WL:   cmd = wr0(REG_F0_BS, f0_bsize[7:0]);
            S_B0WH:   cmd = wr0(REG_F0_BS + 17'd1, f0_bsize[15:8]);
            S_B0RL:   cmd = rd0(REG_F0_BS);
            S_B0RH:   cmd = rd0(REG_F0_BS + 17'd1);
            S_B1WL:   cmd = wr0(REG_F1_BS, f1_bsize[7:0]);
            S_B1WH:   cmd = wr0(REG_F1_BS + 17'd1, f1_bsize[15:8]);
            S_B1RL:   cmd = rd0(REG_F1_BS);
            S_B1RH:   cmd = rd0(REG_F1_BS + 17'd1);
            default:  cmd = '{idx: CMD_GO_IDLE, arg: 32'h0};
        endcase
    end

    assign cmd_idx   = cmd.idx;
    assign cmd_arg   = cmd.arg;
    assign cmd_start = !wait_q && !(st_q inside {S_IDLE, S_DONE, S_ERR});
    assign accept    = wait_q && cmd_done;
    assign can_start = st_q inside {S_IDLE, S_DONE, S_ERR};
    assign bs_entry  = cfg_set_f0_bsize ? S_B0WL : (cfg_set_f1_bsize ? S_B1WL : S_DONE);
    assign after_f0  = cfg_set_f1_bsize ? S_B1WL : S_DONE;

    always_comb begin
        st_d     = st_q;
        wait_d   = wait_q;
        cap_win  = 1'b0;
        cap_rca  = 1'b0;
        poll_clr = 1'b0;
        poll_inc = 1'b0;
        if (start && can_start) begin
            st_d     = S_IORST;
            wait_d   = 1'b0;
            poll_clr = 1'b1;
        end else if (cmd_start) begin
            wait_d = 1'b1;
        end else if (accept) begin
            wait_d = 1'b0;
            unique case (st_q)
                S_IORST:  st_d = S_GORST;
                S_GORST:  st_d = cfg_send_if_cond ? S_IFCOND : S_OCR0;
                S_IFCOND: st_d = S_OCR0;
                S_OCR0: begin
                    cap_win = 1'b1;
                    st_d    = S_OCRN;
                end
                S_OCRN: begin
                    if (cmd_resp[31])   st_d = S_RCA;
                    else if (poll_last) st_d = S_ERR;
                    else                poll_inc = 1'b1;
                end
                S_RCA: begin
                    cap_rca = 1'b1;
                    st_d    = S_SEL;
                end
                S_SEL:  st_d = cfg_bus_4bit ? S_BUS4 : S_FN1;
                S_BUS4: st_d = S_FN1;
                S_FN1:  st_d = cfg_irq_enable ? S_IRQ : bs_entry;
                S_IRQ:  st_d = bs_entry;
                S_B0WL: st_d = S_B0WH;
                S_B0WH: st_d = S_B0RL;
                S_B0RL: st_d = (cmd_resp[7:0] == f0_bsize[7:0])  ? S_B0RH  : S_ERR;
                S_B0RH: st_d = (cmd_resp[7:0] == f0_bsize[15:8]) ? after_f0 : S_ERR;
                S_B1WL: st_d = S_B1WH;
                S_B1WH: st_d = S_B1RL;
                S_B1RL: st_d = (cmd_resp[7:0] == f1_bsize[7:0])  ? S_B1RH  : S_ERR;
                S_B1RH: st_d = (cmd_resp[7:0] == f1_bsize[15:8]) ? S_DONE  : S_ERR;
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            wait_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            wait_q <= wait_d;
        end
    end

    assign init_done = (st_q == S_DONE);
    assign init_err  = (st_q == S_ERR);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> !cmd_start);  // R2
    AST_HOLD_CMD: assert property (@(posedge clk) disable iff (rst)
        (wait_q && !cmd_done) |=> ($stable(cmd_idx) && $stable(cmd_arg)));  // R2
    AST_FN0_ONLY: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && cmd_idx == CMD_RW_DIRECT) |-> (cmd_arg[30:27] == 4'h0));  // R3
    AST_SEL_ARG: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && cmd_idx == CMD_SELECT) |-> (cmd_arg == {rca, 16'h0000}));  // R7
    AST_END_QUIET: assert property (@(posedge clk) disable iff (rst)
        (init_done || init_err) |-> !cmd_start);  // R10
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (init_done && !start) |=> init_done);  // R11

endmodule

// File: tb/sdio_card_init_seq_tb.sv
module sdio_card_init_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PL = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic c_if = 1'b0, c_b4 = 1'b0, c_irq = 1'b0, c_s0 = 1'b0, c_s1 = 1'b0;
    logic [15:0] bs0 = 16'h0200, bs1 = 16'h0200;
    logic cmd_start, cmd_done, init_done, init_err;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg, cmd_resp;
    logic card_done = 1'b0, inj_done = 1'b0;
    logic [31:0] card_resp = 32'h0;

    assign cmd_done = card_done | inj_done;
    assign cmd_resp = card_resp;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdio_card_init_seq #(.POLL_LIMIT(PL)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .cfg_send_if_cond(c_if), .cfg_bus_4bit(c_b4), .cfg_irq_enable(c_irq),
        .cfg_set_f0_bsize(c_s0), .cfg_set_f1_bsize(c_s1),
        .f0_bsize(bs0), .f1_bsize(bs1),
        .cmd_start(cmd_start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .cmd_done(cmd_done), .cmd_resp(cmd_resp),
        .init_done(init_done), .init_err(init_err)
    );

    int errors = 0, checks = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Card model
    int unsigned k_ready = 1, wcnt = 0;
    bit corrupt = 0;
    logic [15:0] rcav = 16'h0001;
    logic [23:0] vw = 24'hFFFF00;
    logic [7:0] card_reg [0:511];

    logic [5:0]  log_idx [0:63];
    logic [31:0] log_arg [0:63];
    int log_n = 0;

    function automatic logic [31:0] card_answer(input logic [5:0] idx, input logic [31:0] arg);
        logic [8:0] a;
        a = arg[17:9];
        case (idx)
            6'd5: begin
                if (arg == 32'h0) return {8'h00, vw};
                wcnt++;
                return {(wcnt >= k_ready), 7'h0, vw};
            end
            6'd3: return {rcav, 16'h0500};
            6'd52: begin
                if (arg[31]) begin
                    card_reg[a] = arg[7:0];
                    return {24'h0, arg[7:0]};
                end
                return {24'h0, card_reg[a] ^ {7'h0, corrupt}};
            end
            default: return 32'h0;
        endcase
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            card_done = 1'b0;
            if (cmd_start && !rst) begin
                logic [5:0] li;
                logic [31:0] la;
                int d;
                li = cmd_idx;
                la = cmd_arg;
                if (log_n < 64) begin
                    log_idx[log_n] = li;
                    log_arg[log_n] = la;
                end
                log_n++;
                d = 1 + int'($urandom % 3);
                repeat (d) begin
                    @(negedge clk);
                    chk(cmd_idx == li && cmd_arg == la && !cmd_start, "R2", "hold until done",
                        {cmd_start, 1'b0, cmd_idx, cmd_arg[23:0]}, {2'b0, li, la[23:0]});
                end
                card_resp = card_answer(li, la);
                card_done = 1'b1;
            end
        end
    end

    // Expected command list
    logic [5:0]  exp_idx [0:63];
    logic [31:0] exp_arg [0:63];
    int exp_n;
    bit exp_err;

    function automatic logic [31:0] a52(input bit wr, input logic [16:0] addr, input logic [7:0] d);
        return {wr, 3'b000, 2'b00, addr, 1'b0, d};
    endfunction

    task automatic add(input logic [5:0] i, input logic [31:0] a);
        exp_idx[exp_n] = i;
        exp_arg[exp_n] = a;
        exp_n++;
    endtask

    task automatic build_exp();
        exp_n = 0;
        exp_err = 0;
        add(52, a52(1, 17'h006, 8'h08));
        add(0, 0);
        if (c_if) add(8, 32'h1AA);
        add(5, 0);
        for (int i = 1; i <= ((k_ready < PL) ? k_ready : PL); i++) add(5, {8'h00, vw});
        if (k_ready > PL) begin exp_err = 1; return; end
        add(3, 0);
        add(7, {rcav, 16'h0});
        if (c_b4) add(52, a52(1, 17'h007, 8'h02));
        add(52, a52(1, 17'h002, 8'h02));
        if (c_irq) add(52, a52(1, 17'h004, 8'h03));
        if (c_s0) begin
            add(52, a52(1, 17'h010, bs0[7:0]));
            add(52, a52(1, 17'h011, bs0[15:8]));
            add(52, a52(0, 17'h010, 8'h00));
            if (corrupt) begin exp_err = 1; return; end
            add(52, a52(0, 17'h011, 8'h00));
        end
        if (c_s1) begin
            add(52, a52(1, 17'h110, bs1[7:0]));
            add(52, a52(1, 17'h111, bs1[15:8]));
            add(52, a52(0, 17'h110, 8'h00));
            if (corrupt) begin exp_err = 1; return; end
            add(52, a52(0, 17'h111, 8'h00));
        end
    endtask

    function automatic string req_of(input logic [5:0] idx, input logic [31:0] arg);
        if (idx == 5) return "R5";
        if (idx == 3 || idx == 7) return "R7";
        if (idx == 0 || idx == 8) return "R4";
        if (arg[25:9] == 17'h006) return "R4";
        if (arg[25:9] == 17'h010 || arg[25:9] == 17'h011 ||
            arg[25:9] == 17'h110 || arg[25:9] == 17'h111) return "R9";
        return "R8";
    endfunction

    task automatic run_case();
        int guard;
        string rq;
        build_exp();
        wcnt = 0;
        @(negedge clk);
        log_n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!init_done && !init_err && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        rq = !exp_err ? "R11" : (k_ready > PL ? "R6" : "R10");
        chk(init_err == exp_err && init_done == !exp_err, rq, "outcome",
            {30'h0, init_done, init_err}, {30'h0, !exp_err, exp_err});
        chk(log_n == exp_n, rq, "command count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk(log_idx[i] == exp_idx[i] && log_arg[i] == exp_arg[i], req_of(exp_idx[i], exp_arg[i]),
                $sformatf("command %0d", i), {log_idx[i], log_arg[i][25:0]}, {exp_idx[i], exp_arg[i][25:0]});
            if (log_idx[i] == 6'd52)
                chk(log_arg[i][30:27] == 4'h0, "R3", "function/raw field", log_arg[i][30:27], 0);
        end
        if (!exp_err) begin
            repeat (4) @(negedge clk);
            chk(init_done && log_n == exp_n, "R11", "hold done, no commands", log_n, exp_n);
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 512; i++) card_reg[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(!cmd_start && !init_done && !init_err, "R1", "reset outputs",
            {29'h0, cmd_start, init_done, init_err}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!cmd_start && !init_done && !init_err, "R1", "idle after reset",
            {29'h0, cmd_start, init_done, init_err}, 0);

        // Directed: everything on, ready on first window poll
        {c_if, c_b4, c_irq, c_s0, c_s1} = 5'b11111;
        bs0 = 16'h0200; bs1 = 16'h0200; k_ready = 1; rcav = 16'h0001;
        run_case();

        // Spurious done while finished is ignored
        inj_done = 1'b1;
        @(negedge clk);
        inj_done = 1'b0;
        repeat (2) @(negedge clk);
        chk(init_done && !cmd_start, "R2", "stray done ignored",
            {30'h0, init_done, cmd_start}, 32'h2);

        // Everything optional off, ready on the last allowed poll
        {c_if, c_b4, c_irq, c_s0, c_s1} = 5'b00000;
        k_ready = PL; vw = 24'h3C8000; rcav = 16'hBEEF;
        run_case();

        // Never ready: poll limit
        {c_if, c_b4, c_irq, c_s0, c_s1} = 5'b10101;
        k_ready = PL + 1;
        run_case();

        // Readback mismatch on function-0 group, then on function-1 only
        {c_if, c_b4, c_irq, c_s0, c_s1} = 5'b01111;
        k_ready = 2; corrupt = 1;
        run_case();
        {c_if, c_b4, c_irq, c_s0, c_s1} = 5'b00001;
        run_case();
        corrupt = 0;

        // Start while a sequence runs is ignored
        {c_if, c_b4, c_irq, c_s0, c_s1} = 5'b00010;
        k_ready = 3;
        build_exp();
        wcnt = 0;
        @(negedge clk); log_n = 0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (6) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!init_done && !init_err) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(log_n == exp_n && init_done, "R11", "mid-run start ignored", log_n, exp_n);

        // Random scenarios
        for (int s = 0; s < 10; s++) begin
            {c_if, c_b4, c_irq, c_s0, c_s1} = 5'($urandom);
            bs0 = 16'($urandom); bs1 = 16'($urandom);
            k_ready = 1 + ($urandom % PL);
            vw = 24'($urandom); rcav = 16'($urandom);
            run_case();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule